// File: doc/BRIEF.md
# SCL Clock Generator with Line Synchronization

This block produces the serial clock for a two-wire bus master. A down-counter loaded from a software-supplied reload value times each low and each high phase of the clock. The block drives the shared open-drain clock line through a single drive-low enable. It releases the line for a high phase and never drives it high. A start-byte strobe launches one byte of nine bit clocks: eight data bits and the acknowledge bit. A four-bit counter reports which bit clock is current.

With line synchronization turned on, the block follows the clock line as it really appears on the bus. After releasing the line, the block does not count its high phase until it sees the line rise. A slower device can therefore stretch the low phase. If another device pulls the line low during a counted high phase, the high phase ends at once, the counter reloads and a fresh low phase begins. The clock used for data transfer is the AND of the internal clock and the sampled line. Synchronization only applies while the internal clock source is selected.

Two wait controls hold the line low to give software time: one after the eighth bit clock and one after the ninth. Each hold lasts until its control is cleared. A stop-release control lets the block give up the bus when a stop condition appears on the lines during a transfer. The block senses both lines through two-flop synchronizers.

Top module: `scl_clock_gen`

## Requirements
- R1: After reset the clock line is released (`sclDriveLow` = 0), `bitCount` is 0, and `byteDone`, `stopDetected` and `effClk`'s hold flags are idle (`byteDone` = 0, `stopDetected` = 0).
- R2: With synchronization not in effect, each low phase lasts reload+1 cycles and each high phase lasts reload+1 cycles, counted on `sclDriveLow`.
- R3: `syncEffective` equals `syncEnable` AND NOT `extClockSel`. With `extClockSel` = 1, the phase timing is that of R2 whatever `syncEnable` is.
- R4: With synchronization in effect, a released phase does not count until the synchronized line is seen rising. With the default two sync stages and no other device, a released phase lasts reload+4 cycles. If another device holds the line low for S extra cycles after the release, the phase lasts reload+4+S cycles.
- R5: With synchronization in effect, another device pulling the line low during a counted high phase ends that phase. The low phase is then driven 3 cycles after the pull-down is applied, and that low phase lasts reload+1 cycles.
- R6: A start-byte strobe in idle clears `bitCount` to 0 and begins a low phase. `bitCount` rises by one at the start of each high phase, up to 9. At the end of the ninth high phase `byteDone` pulses for one cycle and the line stays released. A start-byte strobe while a byte is running is ignored.
- R7: With `waitAfter8` = 1, after the eighth high phase the line is held low with `bitCount` = 8 until `waitAfter8` is cleared. A full low phase of reload+1 cycles then follows, so the line stays low for reload+2 cycles counted from the cycle of the clearing.
- R8: With `waitAfter9` = 1, after the ninth high phase the line is held low until `waitAfter9` is cleared. It is released on the clock edge after the clearing.
- R9: `stopDetected` pulses when the synchronized data line rises while the synchronized clock line is high. A data rise while the clock line is low gives no pulse.
- R10: With `stopRelease` = 1, a stop condition during a byte returns the block to idle. The line is released and stays released, and `bitCount` keeps its value. With `stopRelease` = 0, the byte continues with unchanged timing.
- R11: `effClk` equals NOT `sclDriveLow` AND the clock line after the two sync stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reloadVal | input | CNT_W | Phase length minus one, in clock cycles |
| syncEnable | input | 1 | Request line synchronization |
| extClockSel | input | 1 | External clock source selected; blocks synchronization |
| waitAfter8 | input | 1 | Hold the line low after the eighth bit clock |
| waitAfter9 | input | 1 | Hold the line low after the ninth bit clock |
| stopRelease | input | 1 | Abandon the byte and release the line on a stop condition |
| byteStart | input | 1 | One-cycle strobe that starts a byte from idle |
| sclIn | input | 1 | Sensed level of the clock line |
| sdaIn | input | 1 | Sensed level of the data line |
| sclDriveLow | output | 1 | Open-drain enable: 1 pulls the clock line low |
| effClk | output | 1 | Internal clock AND synchronized line |
| syncEffective | output | 1 | Synchronization actually in force |
| bitCount | output | 4 | Current bit clock, 0 to 9 |
| byteDone | output | 1 | Pulse at the end of the ninth high phase |
| stopDetected | output | 1 | Pulse on a stop condition |

## Verification
The bench keeps the defaults CNT_W = 8 and SYNC_STAGES = 2 and sweeps the reload value from 0 to 7 under every combination of synchronization request and clock-source select. It checks the length of every low and high phase of each full byte. The small reload range includes reload 0, where a one-cycle low phase races the synchronizer delay. It also keeps bytes short enough that the stretch, shortening, hold and stop scenarios can each have their exact cycle counts predicted from the phase formulas. A bus model wired-ANDs a second open-drain driver onto the clock line so the bench can stretch and cut phases.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

  localparam int BIT_CNT_W = 4;
  localparam logic [BIT_CNT_W-1:0] LAST_BIT = 4'd9;
  localparam logic [BIT_CNT_W-1:0] WAIT_BIT = 4'd8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW,
    ST_RISE,
    ST_HIGH,
    ST_HOLD8,
    ST_HOLD9
  } sclState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic cntLoad;
    logic cntRun;
    logic bitClr;
    logic bitInc;
  } dpStrobe_t;

endpackage

// File: rtl/scl_gen_sync.sv
module scl_gen_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= {STAGES{RESET_VAL}};
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/scl_gen_datapath.sv
module scl_gen_datapath
  import scl_gen_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CNT_W-1:0]     reloadVal,
  input  logic                 sclIn,
  input  logic                 sdaIn,
  input  dpStrobe_t            strobe,
  output logic                 cntZero,
  output logic                 sclSync,
  output logic                 sclRise,
  output logic                 sclFall,
  output logic                 stopSeen,
  output logic [BIT_CNT_W-1:0] bitCount
);

  localparam int NUM_PINS = 2;
  localparam int PIN_SCL  = 0;
  localparam int PIN_SDA  = 1;

  logic [NUM_PINS-1:0] pinRaw;
  logic [NUM_PINS-1:0] pinSync;
  logic [NUM_PINS-1:0] pinPrev;
  logic [CNT_W-1:0]    phaseCnt;

  assign pinRaw[PIN_SCL] = sclIn;
  assign pinRaw[PIN_SDA] = sdaIn;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    scl_gen_sync #(
      .STAGES   (SYNC_STAGES),
      .RESET_VAL(1'b1)
    ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (pinRaw[p]),
      .q    (pinSync[p])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pinPrev <= '1;
    else        pinPrev <= pinSync;
  end

  assign sclSync  = pinSync[PIN_SCL];
  assign sclRise  = pinSync[PIN_SCL] & ~pinPrev[PIN_SCL];
  assign sclFall  = ~pinSync[PIN_SCL] & pinPrev[PIN_SCL];
  assign stopSeen = pinSync[PIN_SDA] & ~pinPrev[PIN_SDA] & pinSync[PIN_SCL];

  // Phase down-counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phaseCnt <= '0;
    end else if (strobe.cntLoad) begin
      phaseCnt <= reloadVal;
    end else if (strobe.cntRun && phaseCnt != '0) begin
      phaseCnt <= phaseCnt - 1'b1;
    end
  end

  assign cntZero = (phaseCnt == '0);

  // Bit clock counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitCount <= '0;
    end else if (strobe.bitClr) begin
      bitCount <= '0;
    end else if (strobe.bitInc) begin
      bitCount <= bitCount + 1'b1;
    end
  end

  assert_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.cntLoad |=> phaseCnt == $past(reloadVal));

  assert_bit_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.bitInc && !strobe.bitClr) |=> bitCount == $past(bitCount) + 4'd1);

  assert_bit_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bitCount <= LAST_BIT);

endmodule

// File: rtl/scl_gen_control.sv
module scl_gen_control
  import scl_gen_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 syncEff,
  input  logic                 waitAfter8,
  input  logic                 waitAfter9,
  input  logic                 stopRelease,
  input  logic                 byteStart,
  input  logic                 cntZero,
  input  logic                 sclSync,
  input  logic                 sclRise,
  input  logic                 sclFall,
  input  logic                 stopSeen,
  input  logic [BIT_CNT_W-1:0] bitCount,
  output dpStrobe_t            strobe,
  output logic                 sclDriveLow,
  output logic                 byteDone
);

  sclState_t state, stateNext;
  logic      abortByte;
  logic      highEnd;

  assign abortByte = stopRelease && stopSeen && (state != ST_IDLE);
  assign highEnd   = cntZero || (syncEff && sclFall);

  always_comb begin
    stateNext = state;
    strobe    = '0;
    byteDone  = 1'b0;
    if (abortByte) begin
      stateNext = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (byteStart) begin
            stateNext      = ST_LOW;
            strobe.cntLoad = 1'b1;
            strobe.bitClr  = 1'b1;
          end
        end
        ST_LOW: begin
          if (cntZero) begin
            strobe.bitInc  = 1'b1;
            strobe.cntLoad = 1'b1;
            stateNext      = syncEff ? ST_RISE : ST_HIGH;
          end else begin
            strobe.cntRun = 1'b1;
          end
        end
        ST_RISE: begin
          if (sclRise) begin
            strobe.cntLoad = 1'b1;
            stateNext      = ST_HIGH;
          end
        end
        ST_HIGH: begin
          if (highEnd) begin
            if (bitCount == LAST_BIT) begin
              byteDone  = 1'b1;
              stateNext = waitAfter9 ? ST_HOLD9 : ST_IDLE;
            end else if (bitCount == WAIT_BIT && waitAfter8) begin
              stateNext = ST_HOLD8;
            end else begin
              strobe.cntLoad = 1'b1;
              stateNext      = ST_LOW;
            end
          end else begin
            strobe.cntRun = 1'b1;
          end
        end
        ST_HOLD8: begin
          if (!waitAfter8) begin
            strobe.cntLoad = 1'b1;
            stateNext      = ST_LOW;
          end
        end
        ST_HOLD9: begin
          if (!waitAfter9) stateNext = ST_IDLE;
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end

  assign sclDriveLow = (state == ST_LOW) || (state == ST_HOLD8) || (state == ST_HOLD9);

  assert_rise_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RISE && !sclSync) |=> state == ST_RISE);

  assert_hold_eight_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HOLD8 && waitAfter8 && !abortByte) |=> sclDriveLow);

  assert_hold_nine_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HOLD9 && waitAfter9 && !abortByte) |=> sclDriveLow);

  assert_stop_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    abortByte |=> !sclDriveLow);

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    byteDone |=> !byteDone);

endmodule

// File: rtl/scl_clock_gen.sv
module scl_clock_gen
  import scl_gen_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CNT_W-1:0]     reloadVal,
  input  logic                 syncEnable,
  input  logic                 extClockSel,
  input  logic                 waitAfter8,
  input  logic                 waitAfter9,
  input  logic                 stopRelease,
  input  logic                 byteStart,
  input  logic                 sclIn,
  input  logic                 sdaIn,
  output logic                 sclDriveLow,
  output logic                 effClk,
  output logic                 syncEffective,
  output logic [BIT_CNT_W-1:0] bitCount,
  output logic                 byteDone,
  output logic                 stopDetected
);

  dpStrobe_t strobe;
  logic      cntZero;
  logic      sclSync;
  logic      sclRise;
  logic      sclFall;
  logic      stopSeen;

  assign syncEffective = syncEnable & ~extClockSel;

  scl_gen_datapath #(
    .CNT_W      (CNT_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .reloadVal(reloadVal),
    .sclIn    (sclIn),
    .sdaIn    (sdaIn),
    .strobe   (strobe),
    .cntZero  (cntZero),
    .sclSync  (sclSync),
    .sclRise  (sclRise),
    .sclFall  (sclFall),
    .stopSeen (stopSeen),
    .bitCount (bitCount)
  );

  scl_gen_control u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .syncEff    (syncEffective),
    .waitAfter8 (waitAfter8),
    .waitAfter9 (waitAfter9),
    .stopRelease(stopRelease),
    .byteStart  (byteStart),
    .cntZero    (cntZero),
    .sclSync    (sclSync),
    .sclRise    (sclRise),
    .sclFall    (sclFall),
    .stopSeen   (stopSeen),
    .bitCount   (bitCount),
    .strobe     (strobe),
    .sclDriveLow(sclDriveLow),
    .byteDone   (byteDone)
  );

  assign effClk       = ~sclDriveLow & sclSync;
  assign stopDetected = stopSeen;

  assert_eff_clock_R11: assert property (@(posedge clk) disable iff (!rst_n)
    effClk |-> !sclDriveLow);

endmodule

// File: tb/scl_clock_gen_tb.sv
module scl_clock_gen_tb;

  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [CNT_W-1:0] reloadVal = '0;
  logic             syncEnable = 1'b0;
  logic             extClockSel = 1'b0;
  logic             waitAfter8 = 1'b0;
  logic             waitAfter9 = 1'b0;
  logic             stopRelease = 1'b0;
  logic             byteStart = 1'b0;
  logic             otherLow = 1'b0;
  logic             sdaLine = 1'b1;
  logic             sclDriveLow, effClk, syncEffective, byteDone, stopDetected;
  logic [3:0]       bitCount;
  wire              sclLine = ~(sclDriveLow | otherLow);

  int checks = 0;
  int fails = 0;
  int doneCnt = 0;
  int stopCnt = 0;
  logic effOn = 1'b0;
  logic b1 = 1'b1, b2 = 1'b1;

  always #2 clk = ~clk;

  scl_clock_gen #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .reloadVal(reloadVal), .syncEnable(syncEnable),
    .extClockSel(extClockSel), .waitAfter8(waitAfter8), .waitAfter9(waitAfter9),
    .stopRelease(stopRelease), .byteStart(byteStart), .sclIn(sclLine), .sdaIn(sdaLine),
    .sclDriveLow(sclDriveLow), .effClk(effClk), .syncEffective(syncEffective),
    .bitCount(bitCount), .byteDone(byteDone), .stopDetected(stopDetected)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Bench-side model of the two-stage line sampler
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin b1 <= 1'b1; b2 <= 1'b1; end
    else begin b1 <= sclLine; b2 <= b1; end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (byteDone) doneCnt++;
      if (stopDetected) stopCnt++;
      if (effOn) chk("R11 effClk", int'(effClk), int'(~sclDriveLow & b2));
    end
  end

  task automatic start_byte();
    @(negedge clk) byteStart = 1'b1;
    @(negedge clk) byteStart = 1'b0;
  endtask

  task automatic run_len(input logic lvl, output int n);
    n = 0;
    while (sclDriveLow === lvl && n < 2000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic wait_end();
    int guard = 0;
    while (!(bitCount == 4'd9 && !sclDriveLow) && guard < 5000) begin
      guard++;
      @(negedge clk);
    end
    repeat (40) @(negedge clk);
  endtask

  task automatic sweep_byte(input int r, input logic se, input logic ext);
    int lo, hi, expHi, bad, d0;
    @(negedge clk);
    reloadVal = CNT_W'(r); syncEnable = se; extClockSel = ext;
    expHi = (se && !ext) ? r + 4 : r + 1;
    d0 = doneCnt;
    start_byte();
    for (int k = 1; k <= 9; k++) begin
      run_len(1'b1, lo);
      chk("R2 low phase", lo, r + 1);
      chk("R6 bit count", int'(bitCount), k);
      if (k < 9) begin
        run_len(1'b0, hi);
        chk((se && !ext) ? "R4 synced high phase" : "R2 R3 high phase", hi, expHi);
      end
    end
    bad = 0;
    repeat (expHi + 6) begin
      if (sclDriveLow) bad++;
      @(negedge clk);
    end
    chk("R6 released after ninth clock", bad, 0);
    chk("R6 byte done pulse", doneCnt - d0, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int lo, hi, n, bad, d0, s0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 drive low", int'(sclDriveLow), 0);
    chk("R1 bit count", int'(bitCount), 0);
    chk("R1 byte done", int'(byteDone), 0);
    chk("R1 stop", int'(stopDetected), 0);
    effOn = 1'b1;

    // R3 enable gating
    for (int c = 0; c < 4; c++) begin
      syncEnable = c[0]; extClockSel = c[1];
      #1 chk("R3 syncEffective", int'(syncEffective), int'(c[0] & ~c[1]));
    end

    // R2 R3 R4 R6 sweep
    for (int r = 0; r < 8; r++)
      for (int cfg = 0; cfg < 4; cfg++)
        sweep_byte(r, cfg[0], cfg[1]);

    // R4 stretch by another device
    @(negedge clk); reloadVal = 8'd3; syncEnable = 1'b1; extClockSel = 1'b0;
    start_byte();
    for (int k = 1; k <= 2; k++) begin run_len(1'b1, lo); run_len(1'b0, hi); end
    run_len(1'b1, lo);
    otherLow = 1'b1;
    bad = 0;
    repeat (5) begin if (sclDriveLow) bad++; @(negedge clk); end
    otherLow = 1'b0;
    run_len(1'b0, n);
    chk("R4 stretched phase", n + 5, 3 + 4 + 5);
    chk("R4 released while stretched", bad, 0);
    wait_end();

    // R5 shortened high phase
    @(negedge clk); reloadVal = 8'd5;
    start_byte();
    for (int k = 1; k <= 3; k++) begin run_len(1'b1, lo); run_len(1'b0, hi); end
    run_len(1'b1, lo);
    repeat (4) @(negedge clk);
    otherLow = 1'b1;
    @(negedge clk);
    otherLow = 1'b0;
    run_len(1'b0, n);
    chk("R5 cut high phase", n + 5, 7);
    run_len(1'b1, lo);
    chk("R5 low after cut", lo, 6);
    chk("R5 R6 bit count after cut", int'(bitCount), 5);
    wait_end();

    // R6 start strobe ignored mid-byte
    @(negedge clk); reloadVal = 8'd2; syncEnable = 1'b0;
    start_byte();
    for (int k = 1; k <= 2; k++) begin run_len(1'b1, lo); run_len(1'b0, hi); end
    byteStart = 1'b1;
    @(negedge clk) byteStart = 1'b0;
    run_len(1'b1, lo);
    chk("R6 ignored start low", lo + 1, 3);
    chk("R6 ignored start count", int'(bitCount), 3);
    wait_end();

    // R7 hold after eighth clock
    @(negedge clk); waitAfter8 = 1'b1;
    start_byte();
    for (int k = 1; k <= 8; k++) begin run_len(1'b1, lo); run_len(1'b0, hi); end
    bad = 0;
    repeat (20) begin if (!sclDriveLow || bitCount != 4'd8) bad++; @(negedge clk); end
    chk("R7 hold after eight", bad, 0);
    waitAfter8 = 1'b0;
    run_len(1'b1, lo);
    chk("R7 low after release", lo, 4);
    chk("R7 ninth clock", int'(bitCount), 9);
    wait_end();

    // R8 hold after ninth clock
    @(negedge clk); waitAfter9 = 1'b1;
    d0 = doneCnt;
    start_byte();
    for (int k = 1; k <= 9; k++) begin run_len(1'b1, lo); run_len(1'b0, hi); end
    chk("R8 R6 done before hold", doneCnt - d0, 1);
    bad = 0;
    repeat (20) begin if (!sclDriveLow) bad++; @(negedge clk); end
    chk("R8 hold after nine", bad, 0);
    waitAfter9 = 1'b0;
    run_len(1'b1, lo);
    chk("R8 release edge", lo, 1);
    repeat (10) @(negedge clk);

    // R9 R10 stop with release enabled
    @(negedge clk); reloadVal = 8'd20; syncEnable = 1'b1; stopRelease = 1'b1;
    sdaLine = 1'b0;
    repeat (6) @(negedge clk);
    s0 = stopCnt;
    start_byte();
    repeat (3) @(negedge clk);
    sdaLine = 1'b1;
    repeat (3) @(negedge clk);
    sdaLine = 1'b0;
    chk("R9 no stop with clock low", stopCnt - s0, 0);
    run_len(1'b1, lo);
    repeat (6) @(negedge clk);
    sdaLine = 1'b1;
    bad = 0;
    repeat (60) begin if (sclDriveLow) bad++; @(negedge clk); end
    chk("R9 stop seen", stopCnt - s0, 1);
    chk("R10 line released", bad, 0);
    chk("R10 count kept", int'(bitCount), 1);

    // R10 stop with release disabled
    @(negedge clk); stopRelease = 1'b0; sdaLine = 1'b0;
    repeat (6) @(negedge clk);
    s0 = stopCnt;
    start_byte();
    run_len(1'b1, lo);
    repeat (6) @(negedge clk);
    sdaLine = 1'b1;
    run_len(1'b0, n);
    chk("R9 stop seen again", stopCnt - s0, 1);
    chk("R10 clock continues", n + 6, 24);
    wait_end();

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule